// File: doc/BRIEF.md
# Subcarrier Manchester Reply Encoder

This block turns the byte stream of a vicinity tag's controller into the on/off control for the antenna load switch while the tag answers a reader. It runs on the recovered 13.56 MHz carrier clock, so every time in the block is a count of carrier cycles. After the controller flags the end of a reader request, the block waits a fixed reply delay. It then sends a start-of-frame, the data bytes as Manchester symbols, and an end-of-frame. Throughout the reply a busy flag is held high.

The reply format and data rate are taken from three select inputs, which are latched when the request end is seen. In the single-subcarrier format the modulated half-bits carry a square wave at carrier/32 and the other half-bits are silent. In the dual-subcarrier format the silent half-bits instead carry a carrier/28 square wave, and their cycle count is chosen so the halves nearly match in length. Standard and fast timing each come in a low and a high rate. Fast timing always uses the single-subcarrier format. Each byte is taken from the controller at the moment it starts to be sent, and a one-cycle pulse reports the take.

Top module: `resp_encoder`

## Requirements
- R1: The first cycle of a reply appears on `busy`/`mod_out` exactly RESP_DELAY (default 4352) clock cycles after the edge that captured `req_end`.
- R2: A carrier/32 half-bit is a square wave that is high for 16 cycles and then low for 16 cycles, repeated, starting high at the start of the half-bit.
- R3: In the single-subcarrier format, logic 0 is a subcarrier half-bit followed by a silent half-bit, and logic 1 is the reverse. A half-bit lasts 8 subcarrier periods at standard high rate (`sel_rate_high`=1) and 32 at standard low rate.
- R4: With `sel_fast`=1, a half-bit lasts 4 subcarrier periods at high rate and 16 at low rate.
- R5: In the dual-subcarrier format (`sel_two_sub`=1, `sel_fast`=0), the silent half-bit is replaced by a carrier/28 square wave (14 high, 14 low). It lasts 9 periods at high rate and 36 at low rate, which gives bits of 508 and 2032 cycles.
- R6: When `sel_fast`=1, `sel_two_sub` has no effect and the reply uses the single-subcarrier format.
- R7: The start-of-frame is three half-bits of the non-subcarrier kind, then three carrier/32 half-bits, then a logic 1. The end-of-frame is a logic 0, then three carrier/32 half-bits, then three half-bits of the non-subcarrier kind.
- R8: Bytes go out least-significant bit first. `byte_data`/`byte_last` are sampled when a byte starts, and `byte_take` pulses for one cycle right after each sample. The end-of-frame follows the byte that was sampled with `byte_last`=1.
- R9: After reset and between replies, `busy` and `mod_out` are 0. `busy` is 1 for exactly the reply duration.
- R10: A `req_end` pulse that arrives while a reply is pending or being sent is ignored. This includes the last reply cycle.
- R11: Changes to the select inputs after `req_end` has been captured have no effect on that reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst | input | 1 | Synchronous active-high reset |
| req_end | input | 1 | One-cycle pulse: reader request ended |
| sel_two_sub | input | 1 | 1 = dual-subcarrier format |
| sel_rate_high | input | 1 | 1 = high data rate |
| sel_fast | input | 1 | 1 = fast (doubled) timing |
| byte_data | input | 8 | Next reply byte |
| byte_last | input | 1 | Marks the next byte as the final one |
| byte_take | output | 1 | Pulse: `byte_data` was consumed |
| mod_out | output | 1 | Load modulation control |
| busy | output | 1 | High while the reply is sent |

## Verification
The delicate coincidence is a new request end that arrives on the same clock edge on which the end-of-frame finishes and the sequencer falls back to idle. A second coincidence is a select input that changes on a cycle where a segment boundary loads new timing. The bench pulses `req_end` so that it is captured on the last reply edge, and in another run mid-frame. It also flips every select input partway through a reply. A behavioural waveform model, built only from the requirement timings, is compared against `busy` and `mod_out` on every cycle. The bench then watches idle for longer than the reply delay to show that no second reply starts.

// File: rtl/resp_enc_pkg.sv
package resp_enc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SOF_Q,
    ST_SOF_M,
    ST_SOF_B1,
    ST_SOF_B2,
    ST_BIT_H1,
    ST_BIT_H2,
    ST_EOF_B1,
    ST_EOF_B2,
    ST_EOF_M,
    ST_EOF_Q
  } enc_state_t;

  // SEG_TONE: carrier/32 subcarrier; SEG_ALT: silence or carrier/28 subcarrier
  typedef enum logic {SEG_TONE, SEG_ALT} seg_kind_t;

  typedef struct packed {
    logic two_sub;
    logic rate_high;
    logic fast;
  } enc_cfg_t;

endpackage

// File: rtl/resp_delay_timer.sv
module resp_delay_timer #(
  parameter int RESP_DELAY = 4352
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);
  localparam int DLY_W = $clog2(RESP_DELAY + 1);
  localparam logic [DLY_W-1:0] FIRE_AT = DLY_W'(RESP_DELAY - 2);

  logic             running;
  logic [DLY_W-1:0] cnt;

  assign fire = running && (cnt == FIRE_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
      if (fire) running <= 1'b0;
    end
  end

  // R1: the delay expires once and the timer stops
  assert_fire_single_R1: assert property (@(posedge clk) disable iff (rst)
    fire |=> !running);
  // R1: counting advances one step per cycle while running
  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (running && !fire && !start) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/resp_frame_seq.sv
module resp_frame_seq
  import resp_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_end,
  input  enc_cfg_t   cfg_in,
  input  logic [7:0] byte_data,
  input  logic       byte_last,
  input  logic       fire,
  input  logic       seg_last,
  output logic       tmr_start,
  output seg_kind_t  seg_kind,
  output logic       seg_triple,
  output logic       active,
  output enc_cfg_t   cfg_q,
  output logic       byte_take
);
  enc_state_t state;
  logic [7:0] shreg;
  logic [2:0] bitcnt;
  logic       last_q;
  logic       take_q;
  logic       cur_bit;

  assign cur_bit   = shreg[0];
  assign tmr_start = (state == ST_IDLE) && req_end;
  assign active    = (state != ST_IDLE) && (state != ST_WAIT);
  assign byte_take = take_q;

  always_comb begin
    seg_kind   = SEG_ALT;
    seg_triple = 1'b0;
    unique case (state)
      ST_SOF_Q:  begin seg_kind = SEG_ALT;  seg_triple = 1'b1; end
      ST_SOF_M:  begin seg_kind = SEG_TONE; seg_triple = 1'b1; end
      ST_SOF_B1: seg_kind = SEG_ALT;
      ST_SOF_B2: seg_kind = SEG_TONE;
      ST_BIT_H1: seg_kind = cur_bit ? SEG_ALT : SEG_TONE;
      ST_BIT_H2: seg_kind = cur_bit ? SEG_TONE : SEG_ALT;
      ST_EOF_B1: seg_kind = SEG_TONE;
      ST_EOF_B2: seg_kind = SEG_ALT;
      ST_EOF_M:  begin seg_kind = SEG_TONE; seg_triple = 1'b1; end
      ST_EOF_Q:  begin seg_kind = SEG_ALT;  seg_triple = 1'b1; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      last_q <= 1'b0;
      cfg_q  <= '0;
      take_q <= 1'b0;
    end else begin
      take_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_end) begin
          state <= ST_WAIT;
          cfg_q <= cfg_in;
        end
        ST_WAIT: if (fire) begin
          state  <= ST_SOF_Q;
          shreg  <= byte_data;
          last_q <= byte_last;
          bitcnt <= '0;
          take_q <= 1'b1;
        end
        ST_SOF_Q:  if (seg_last) state <= ST_SOF_M;
        ST_SOF_M:  if (seg_last) state <= ST_SOF_B1;
        ST_SOF_B1: if (seg_last) state <= ST_SOF_B2;
        ST_SOF_B2: if (seg_last) state <= ST_BIT_H1;
        ST_BIT_H1: if (seg_last) state <= ST_BIT_H2;
        ST_BIT_H2: if (seg_last) begin
          if (bitcnt == 3'd7) begin
            if (last_q) begin
              state <= ST_EOF_B1;
            end else begin
              state  <= ST_BIT_H1;
              shreg  <= byte_data;
              last_q <= byte_last;
              bitcnt <= '0;
              take_q <= 1'b1;
            end
          end else begin
            state  <= ST_BIT_H1;
            shreg  <= {1'b0, shreg[7:1]};
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_EOF_B1: if (seg_last) state <= ST_EOF_B2;
        ST_EOF_B2: if (seg_last) state <= ST_EOF_M;
        ST_EOF_M:  if (seg_last) state <= ST_EOF_Q;
        ST_EOF_Q:  if (seg_last) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R8: each byte is acknowledged by a single-cycle pulse
  assert_take_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    take_q |=> !take_q);
  // R10: a request end during a reply never re-arms the delay
  assert_req_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (active && req_end) |=> (state != ST_WAIT));
  // R11: latched selection is frozen outside idle
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(cfg_q));

endmodule

// File: rtl/resp_seg_gen.sv
module resp_seg_gen
  import resp_enc_pkg::*;
#(
  parameter int TONE_DIV = 32,
  parameter int ALT_DIV  = 28,
  parameter int HALF_STD = 8,
  parameter int LOW_MUL  = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      active,
  input  seg_kind_t kind,
  input  logic      triple,
  input  enc_cfg_t  cfg,
  output logic      wave,
  output logic      seg_last
);
  localparam int HALF_SH = HALF_STD;
  localparam int HALF_SL = HALF_STD * LOW_MUL;
  localparam int HALF_FH = HALF_SH / 2;
  localparam int HALF_FL = HALF_SL / 2;
  localparam int MAX_CYC = 3 * (HALF_SL + HALF_SL / 8);
  localparam int CYC_W   = $clog2(MAX_CYC + 1);
  localparam int PH_W    = $clog2(TONE_DIV);

  localparam logic [PH_W-1:0] TONE_M1 = PH_W'(TONE_DIV - 1);
  localparam logic [PH_W-1:0] ALT_M1  = PH_W'(ALT_DIV - 1);
  localparam logic [PH_W-1:0] TONE_HF = PH_W'(TONE_DIV / 2);
  localparam logic [PH_W-1:0] ALT_HF  = PH_W'(ALT_DIV / 2);

  logic             two_eff;
  logic             alt_two;
  logic [CYC_W-1:0] half_c;
  logic [CYC_W-1:0] base_c;
  logic [CYC_W-1:0] cyc_c;
  logic [PH_W-1:0]  per_m1;
  logic [PH_W-1:0]  per_hf;
  logic [PH_W-1:0]  ph;
  logic [CYC_W-1:0] sc;
  logic             ph_last;

  assign two_eff = cfg.two_sub && !cfg.fast;
  assign alt_two = (kind == SEG_ALT) && two_eff;

  always_comb begin
    unique case ({cfg.fast, cfg.rate_high})
      2'b00:   half_c = CYC_W'(HALF_SL);
      2'b01:   half_c = CYC_W'(HALF_SH);
      2'b10:   half_c = CYC_W'(HALF_FL);
      default: half_c = CYC_W'(HALF_FH);
    endcase
  end

  assign base_c  = alt_two ? (half_c + (half_c >> 3)) : half_c;
  assign cyc_c   = triple ? (base_c + (base_c << 1)) : base_c;
  assign per_m1  = alt_two ? ALT_M1 : TONE_M1;
  assign per_hf  = alt_two ? ALT_HF : TONE_HF;
  assign ph_last = (ph == per_m1);
  assign seg_last = active && ph_last && (sc == cyc_c - 1'b1);
  assign wave    = active && ((kind == SEG_TONE) || two_eff) && (ph < per_hf);

  always_ff @(posedge clk) begin
    if (rst || !active || seg_last) begin
      ph <= '0;
      sc <= '0;
    end else if (ph_last) begin
      ph <= '0;
      sc <= sc + 1'b1;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  // R2: phase stays inside the selected subcarrier period
  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    active |-> (ph <= per_m1));
  // R5: subcarrier period count never exceeds the segment length
  assert_count_range_R5: assert property (@(posedge clk) disable iff (rst)
    active |-> (sc < cyc_c));

endmodule

// File: rtl/resp_encoder.sv
module resp_encoder
  import resp_enc_pkg::*;
#(
  parameter int RESP_DELAY = 4352,
  parameter int TONE_DIV   = 32,
  parameter int ALT_DIV    = 28,
  parameter int HALF_STD   = 8,
  parameter int LOW_MUL    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_end,
  input  logic       sel_two_sub,
  input  logic       sel_rate_high,
  input  logic       sel_fast,
  input  logic [7:0] byte_data,
  input  logic       byte_last,
  output logic       byte_take,
  output logic       mod_out,
  output logic       busy
);
  enc_cfg_t  cfg_in;
  enc_cfg_t  cfg_q;
  logic      tmr_start;
  logic      fire;
  logic      seg_last;
  seg_kind_t seg_kind;
  logic      seg_triple;
  logic      active;
  logic      wave;
  logic      mod_q;
  logic      busy_q;

  assign cfg_in = '{two_sub: sel_two_sub, rate_high: sel_rate_high, fast: sel_fast};

  resp_delay_timer #(.RESP_DELAY(RESP_DELAY)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (tmr_start),
    .fire  (fire)
  );

  resp_frame_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_end    (req_end),
    .cfg_in     (cfg_in),
    .byte_data  (byte_data),
    .byte_last  (byte_last),
    .fire       (fire),
    .seg_last   (seg_last),
    .tmr_start  (tmr_start),
    .seg_kind   (seg_kind),
    .seg_triple (seg_triple),
    .active     (active),
    .cfg_q      (cfg_q),
    .byte_take  (byte_take)
  );

  resp_seg_gen #(
    .TONE_DIV (TONE_DIV),
    .ALT_DIV  (ALT_DIV),
    .HALF_STD (HALF_STD),
    .LOW_MUL  (LOW_MUL)
  ) u_gen (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .kind     (seg_kind),
    .triple   (seg_triple),
    .cfg      (cfg_q),
    .wave     (wave),
    .seg_last (seg_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      mod_q  <= wave;
      busy_q <= active;
    end
  end

  assign mod_out = mod_q;
  assign busy    = busy_q;

  // R9: no load modulation outside a reply
  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !mod_q);

endmodule

// File: tb/sim_resp_encoder.sv
`timescale 1ns/1ps
module sim_resp_encoder;
  localparam int D = 4352;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_end = 1'b0;
  logic       sel_two_sub = 1'b0;
  logic       sel_rate_high = 1'b0;
  logic       sel_fast = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       byte_last = 1'b0;
  logic       byte_take;
  logic       mod_out;
  logic       busy;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  bit   wf[$];
  logic [7:0] bq[$];
  int   bidx;
  int   takes;

  always #2.5 clk = ~clk;

  resp_encoder u0 (
    .clk(clk), .rst(rst), .req_end(req_end),
    .sel_two_sub(sel_two_sub), .sel_rate_high(sel_rate_high), .sel_fast(sel_fast),
    .byte_data(byte_data), .byte_last(byte_last), .byte_take(byte_take),
    .mod_out(mod_out), .busy(busy)
  );

  task automatic check_bits(string tag, bit eb, bit em);
    checks++;
    if (busy !== eb || mod_out !== em) begin
      errs++;
      $display("FAIL %s at %0t: busy=%b mod_out=%b expected busy=%b mod_out=%b",
               tag, $time, busy, mod_out, eb, em);
    end
  endtask

  // one negedge: compare, then serve the byte handshake
  task automatic tick(string tag, bit eb, bit em);
    @(negedge clk);
    check_bits(tag, eb, em);
    if (byte_take === 1'b1) begin
      takes++;
      bidx++;
      if (bidx < bq.size()) begin
        byte_data = bq[bidx];
        byte_last = (bidx == bq.size() - 1);
      end
    end
  endtask

  // behavioural half-bit model: tone = carrier/32, alt = silence or carrier/28
  function automatic void add_half(bit tone, int mult, bit two, int n);
    if (tone) begin
      for (int c = 0; c < mult * n; c++)
        for (int p = 0; p < 32; p++) wf.push_back(p < 16);
    end else if (two) begin
      for (int c = 0; c < mult * (n + n / 8); c++)
        for (int p = 0; p < 28; p++) wf.push_back(p < 14);
    end else begin
      for (int c = 0; c < mult * n * 32; c++) wf.push_back(1'b0);
    end
  endfunction

  function automatic void build(bit two_sel, bit high, bit fast);
    bit two = two_sel && !fast;  // R6
    int n = fast ? (high ? 4 : 16) : (high ? 8 : 32);
    wf.delete();
    add_half(0, 3, two, n); add_half(1, 3, two, n);   // R7 start
    add_half(0, 1, two, n); add_half(1, 1, two, n);
    foreach (bq[i])
      for (int b = 0; b < 8; b++) begin                 // R8 LSB first
        if (bq[i][b]) begin add_half(0, 1, two, n); add_half(1, 1, two, n); end
        else          begin add_half(1, 1, two, n); add_half(0, 1, two, n); end
      end
    add_half(1, 1, two, n); add_half(0, 1, two, n);   // R7 end
    add_half(1, 3, two, n); add_half(0, 3, two, n);
  endfunction

  task automatic run_frame(string tag, bit two, bit high, bit fast,
                           int ignore_at, int perturb_at, int tail);
    build(two, high, fast);
    bidx = 0; takes = 0;
    byte_data = bq[0];
    byte_last = (bq.size() == 1);
    @(negedge clk);
    sel_two_sub = two; sel_rate_high = high; sel_fast = fast;
    req_end = 1'b1;
    tick({"R1 R9 idle ", tag}, 1'b0, 1'b0);
    req_end = 1'b0;
    for (int j = 1; j < D; j++) tick({"R1 delay ", tag}, 1'b0, 1'b0);
    for (int k = 0; k < wf.size(); k++) begin
      tick({"R2 R3 wave ", tag}, 1'b1, wf[k]);
      req_end = (k == ignore_at);
      if (k == perturb_at) begin            // R11
        sel_two_sub = ~sel_two_sub; sel_rate_high = ~sel_rate_high; sel_fast = ~sel_fast;
      end
    end
    req_end = 1'b0;
    for (int j = 0; j < tail; j++) tick({"R9 R10 after ", tag}, 1'b0, 1'b0);
    checks++;
    if (takes != bq.size()) begin
      errs++;
      $display("FAIL R8 byte_take count %s: got %0d expected %0d", tag, takes, bq.size());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R9 reset state
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || mod_out !== 1'b0 || byte_take !== 1'b0) begin
      errs++;
      $display("FAIL R9 reset: busy=%b mod=%b take=%b expected 0 0 0", busy, mod_out, byte_take);
    end
    // R3 R7 R8 R11: two bytes, selects flipped mid-reply
    bq = '{8'hA5, 8'h3C};
    run_frame("R3 R7 R8 R11 std-high", 0, 1, 0, -1, 300, 20);
    bq = '{8'h96};
    run_frame("R5 two-high", 1, 1, 0, -1, -1, 20);
    bq = '{8'h0F};
    run_frame("R4 fast-high", 0, 1, 1, -1, -1, 20);
    bq = '{8'h81};
    run_frame("R4 fast-low", 0, 0, 1, -1, -1, 20);
    bq = '{8'h5A};
    run_frame("R6 fast-two-high", 1, 1, 1, -1, -1, 20);
    bq = '{8'hC3};
    run_frame("R3 std-low", 0, 0, 0, 700, -1, 20);
    bq = '{8'h69};
    run_frame("R5 two-low", 1, 0, 0, -1, -1, 20);
    // R10: request end captured on the final reply edge
    bq = '{8'hE1};
    build(0, 1, 0);
    run_frame("R10 last-edge", 0, 1, 0, wf.size() - 2, -1, D + 20);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

endmodule